// File: doc/BRIEF.md
# Spare-Block Remapper with Write Lock

This block sits between the flash management logic and the physical flash array. It turns a logical block number into a physical block number using a remap table. A fixed pool of spare physical blocks stays out of normal use. At reset every logical block maps onto the physical block with the same index. The spare blocks sit just above the logical range and no lookup returns them until one has been assigned.

When the owner of a logical block finds that the block's current physical home has failed, it reports the logical number. The block then takes the next free spare and points the logical entry at it. It also raises a copy request that names the old and new physical blocks, so that the surviving data can be moved. When the last spare has been used, the block enters a write-locked state. Program and erase lookups are refused, but read lookups still translate, so stored data can be recovered.

Top module: `spare_remap`

## Requirements
- R1: After reset, logical block i maps to physical block i, `spares_left_o` equals the spare count (8), `locked_o` is 0, `cp_req_o` is 0 and `fail_ready_o` is 1.
- R2: A lookup is combinational. In the same cycle as `lkp_req_i`, `lkp_phys_o` shows the current mapping of `lkp_log_i`. For a read (op code 0), `lkp_valid_o` is 1 and `lkp_refused_o` is 0.
- R3: Spare physical indices start at the logical block count (64..71). No lookup returns a spare until that spare is assigned, and spares are handed out in ascending order starting at 64.
- R4: A report is accepted when `fail_valid_i` and `fail_ready_o` are both high at a clock edge and spares remain. From the next cycle on, the reported logical block maps to the next unused spare.
- R5: The edge that accepts a report also raises `cp_req_o`. `cp_src_o` carries the previous physical block and `cp_dst_o` carries the new spare. All three hold steady until an edge with `cp_ack_i` high, after which `cp_req_o` is 0.
- R6: While a copy request is pending, `fail_ready_o` is 0. A report offered then does not change the mapping and consumes no spare.
- R7: A failure report against a logical block that already sits on a spare consumes another spare in the same way, and `cp_src_o` names the old spare.
- R8: Each accepted report lowers `spares_left_o` by one. `locked_o` goes high when it reaches zero and stays high until reset.
- R9: While locked, program (op 1) and erase (op 2) lookups give `lkp_valid_o` 0 and `lkp_refused_o` 1. Read lookups still give `lkp_valid_o` 1 and the correct physical index.
- R10: A failure report accepted while locked is ignored. No copy request is raised and the mapping is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_req_i | input | 1 | Lookup request |
| lkp_log_i | input | 6 | Logical block number to translate |
| lkp_op_i | input | 2 | Access kind: 0 read, 1 program, 2 erase, 3 treated as modifying |
| lkp_phys_o | output | 7 | Physical block for the looked-up logical block |
| lkp_valid_o | output | 1 | Translation is granted |
| lkp_refused_o | output | 1 | Modifying access refused because of the lock |
| fail_valid_i | input | 1 | Failure report offered |
| fail_log_i | input | 6 | Logical block whose physical home failed |
| fail_ready_o | output | 1 | A failure report can be accepted |
| cp_req_o | output | 1 | Data copy requested |
| cp_src_o | output | 7 | Physical block to copy from |
| cp_dst_o | output | 7 | Physical spare block to copy into |
| cp_ack_i | input | 1 | Copy request acknowledged |
| spares_left_o | output | 4 | Number of unused spares |
| locked_o | output | 1 | Write lock active |

## Verification
On every cycle, the assertions check the following:
- a pending copy request and its indices stay steady until acknowledged;
- the copy destination always lies in the spare range;
- each accepted report lowers the spare count by exactly one, and a pending copy blocks any decrement;
- the lock never drops once set;
- a table update lands in the entry that was reported.

Only the bench scenarios can show the following:
- the mapping values seen through lookups;
- the ascending order in which spares are handed out;
- a second failure on an already-remapped block;
- that reports are ignored both while a copy is pending and once the pool is exhausted;
- that reads keep working under the lock while program and erase are refused.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } acc_op_e;
endpackage

// File: rtl/remap_table.sv
module remap_table #(
  parameter int N_LOG  = 64,
  parameter int LOG_W  = 6,
  parameter int PHYS_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LOG_W-1:0]  rd_idx_i,
  output logic [PHYS_W-1:0] rd_phys_o,
  input  logic [LOG_W-1:0]  upd_idx_i,
  output logic [PHYS_W-1:0] upd_old_o,
  input  logic              upd_i,
  input  logic [PHYS_W-1:0] upd_phys_i
);
  logic [PHYS_W-1:0] tbl_q [N_LOG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LOG; i++) tbl_q[i] <= PHYS_W'(i);
    end else if (upd_i) begin
      tbl_q[upd_idx_i] <= upd_phys_i;
    end
  end

  assign rd_phys_o = tbl_q[rd_idx_i];
  assign upd_old_o = tbl_q[upd_idx_i];

  AST_TBL_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> tbl_q[$past(upd_idx_i)] == $past(upd_phys_i)); // R4
endmodule

// File: rtl/spare_pool.sv
module spare_pool #(
  parameter int N_LOG   = 64,
  parameter int N_SPARE = 8,
  parameter int PHYS_W  = 7,
  parameter int CNT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  output logic [CNT_W-1:0]  left_o,
  output logic [PHYS_W-1:0] next_phys_o,
  output logic              empty_o
);
  localparam logic [PHYS_W-1:0] BASE  = PHYS_W'(N_LOG);
  localparam logic [CNT_W-1:0]  TOTAL = CNT_W'(N_SPARE);

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] used;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= TOTAL;
    else if (take_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  // spares consumed in ascending order above the logical range
  assign used        = TOTAL - left_q;
  assign next_phys_o = BASE + PHYS_W'(used);
  assign left_o      = left_q;
  assign empty_o     = (left_q == '0);

  AST_POOL_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && left_q != '0) |=> left_q == $past(left_q) - 1'b1); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |=> empty_o); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_q <= TOTAL); // R8
endmodule

// File: rtl/copy_req.sv
module copy_req #(
  parameter int PHYS_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PHYS_W-1:0] src_i,
  input  logic [PHYS_W-1:0] dst_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic [PHYS_W-1:0] src_o,
  output logic [PHYS_W-1:0] dst_o
);
  logic              busy_q;
  logic [PHYS_W-1:0] src_q, dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      src_q  <= src_i;
      dst_q  <= dst_i;
    end else if (busy_q && ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;

  AST_CP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i) |=> busy_q && $stable(src_q) && $stable(dst_q)); // R5
  AST_CP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i && !load_i) |=> !busy_q); // R5
endmodule

// File: rtl/spare_remap.sv
module spare_remap
  import remap_pkg::*;
#(
  parameter int N_LOG   = 64,
  parameter int N_SPARE = 8,
  parameter int LOG_W   = $clog2(N_LOG),
  parameter int PHYS_W  = $clog2(N_LOG + N_SPARE),
  parameter int CNT_W   = $clog2(N_SPARE + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_req_i,
  input  logic [LOG_W-1:0]  lkp_log_i,
  input  logic [1:0]        lkp_op_i,
  output logic [PHYS_W-1:0] lkp_phys_o,
  output logic              lkp_valid_o,
  output logic              lkp_refused_o,
  input  logic              fail_valid_i,
  input  logic [LOG_W-1:0]  fail_log_i,
  output logic              fail_ready_o,
  output logic              cp_req_o,
  output logic [PHYS_W-1:0] cp_src_o,
  output logic [PHYS_W-1:0] cp_dst_o,
  input  logic              cp_ack_i,
  output logic [CNT_W-1:0]  spares_left_o,
  output logic              locked_o
);
  logic              cp_busy, pool_empty, take;
  logic [PHYS_W-1:0] old_phys, new_phys;
  acc_op_e           op;

  assign op           = acc_op_e'(lkp_op_i);
  assign fail_ready_o = !cp_busy;
  assign take         = fail_valid_i && !cp_busy && !pool_empty;

  remap_table #(.N_LOG(N_LOG), .LOG_W(LOG_W), .PHYS_W(PHYS_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (lkp_log_i),
    .rd_phys_o  (lkp_phys_o),
    .upd_idx_i  (fail_log_i),
    .upd_old_o  (old_phys),
    .upd_i      (take),
    .upd_phys_i (new_phys)
  );

  spare_pool #(.N_LOG(N_LOG), .N_SPARE(N_SPARE), .PHYS_W(PHYS_W), .CNT_W(CNT_W)) u_pool (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .left_o      (spares_left_o),
    .next_phys_o (new_phys),
    .empty_o     (pool_empty)
  );

  copy_req #(.PHYS_W(PHYS_W)) u_cp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take),
    .src_i  (old_phys),
    .dst_i  (new_phys),
    .ack_i  (cp_ack_i),
    .busy_o (cp_busy),
    .src_o  (cp_src_o),
    .dst_o  (cp_dst_o)
  );

  assign cp_req_o      = cp_busy;
  assign locked_o      = pool_empty;
  assign lkp_valid_o   = lkp_req_i && (op == OP_READ || !pool_empty);
  assign lkp_refused_o = lkp_req_i && pool_empty && op != OP_READ;

  AST_DST_IN_POOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_req_o |-> cp_dst_o >= PHYS_W'(N_LOG)); // R3
  AST_NO_TAKE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_req_o && !cp_ack_i) |=> spares_left_o == $past(spares_left_o)); // R6
  AST_LOCKED_NO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !cp_req_o) |=> !cp_req_o); // R10
endmodule

// File: tb/tb_spare_remap.sv
module tb_spare_remap;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 64;
  localparam int NS = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lkp_req = 1'b0;
  logic [5:0] lkp_log = '0;
  logic [1:0] lkp_op = '0;
  logic [6:0] lkp_phys;
  logic       lkp_valid, lkp_refused;
  logic       fail_valid = 1'b0;
  logic [5:0] fail_log = '0;
  logic       fail_ready, cp_req, cp_ack = 1'b0, locked;
  logic [6:0] cp_src, cp_dst;
  logic [3:0] spares_left;

  always #(CLK_PERIOD/2) clk = ~clk;

  spare_remap dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_req_i(lkp_req), .lkp_log_i(lkp_log), .lkp_op_i(lkp_op),
    .lkp_phys_o(lkp_phys), .lkp_valid_o(lkp_valid), .lkp_refused_o(lkp_refused),
    .fail_valid_i(fail_valid), .fail_log_i(fail_log), .fail_ready_o(fail_ready),
    .cp_req_o(cp_req), .cp_src_o(cp_src), .cp_dst_o(cp_dst), .cp_ack_i(cp_ack),
    .spares_left_o(spares_left), .locked_o(locked)
  );

  typedef struct {
    int    kind;
    int    e0;
    int    e1;
    int    e2;
    string tag;
  } item_t;

  item_t q[$];
  event  smp_ev;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  int m_map [NL];
  int m_left, m_src, m_dst;
  bit m_pend;

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(smp_ev);
      while (q.size() > 0) begin
        it = q.pop_front();
        case (it.kind)
          0: begin
            cmp(it.tag, "phys", int'(lkp_phys), it.e0);
            cmp(it.tag, "valid", int'(lkp_valid), it.e1);
            cmp(it.tag, "refused", int'(lkp_refused), it.e2);
          end
          1: begin
            cmp(it.tag, "spares_left", int'(spares_left), it.e0);
            cmp(it.tag, "locked", int'(locked), it.e1);
            cmp(it.tag, "fail_ready", int'(fail_ready), it.e2);
          end
          default: begin
            cmp(it.tag, "cp_req", int'(cp_req), it.e0);
            if (it.e0 != 0) begin
              cmp(it.tag, "cp_src", int'(cp_src), it.e1);
              cmp(it.tag, "cp_dst", int'(cp_dst), it.e2);
            end
          end
        endcase
      end
    end
  end

  task automatic push(int k, int a, int b, int c, string tag);
    item_t it;
    it.kind = k; it.e0 = a; it.e1 = b; it.e2 = c; it.tag = tag;
    q.push_back(it);
    -> smp_ev;
    #1;
  endtask

  task automatic chk_lookup(int l, int op, string tag);
    bit lk, ok;
    @(negedge clk);
    lkp_req = 1'b1; lkp_log = 6'(l); lkp_op = 2'(op);
    #1;
    lk = (m_left == 0);
    ok = (op == 0) || !lk;
    push(0, m_map[l], int'(ok), int'(!ok), tag);
    lkp_req = 1'b0;
  endtask

  task automatic chk_status(string tag);
    @(negedge clk);
    #1;
    push(1, m_left, int'(m_left == 0), int'(!m_pend), tag);
  endtask

  task automatic chk_copy(string tag);
    @(negedge clk);
    #1;
    push(2, int'(m_pend), m_src, m_dst, tag);
  endtask

  task automatic report(int l);
    bit acc;
    @(negedge clk);
    fail_valid = 1'b1; fail_log = 6'(l);
    @(posedge clk);
    acc = !m_pend && m_left > 0;
    #1;
    fail_valid = 1'b0;
    if (acc) begin
      m_src = m_map[l];
      m_dst = NL + (NS - m_left);
      m_map[l] = m_dst;
      m_left--;
      m_pend = 1'b1;
    end
  endtask

  task automatic ack();
    @(negedge clk);
    cp_ack = 1'b1;
    @(posedge clk);
    #1;
    cp_ack = 1'b0;
    m_pend = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < NL; i++) m_map[i] = i;
    m_left = NS; m_pend = 0; m_src = 0; m_dst = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk_status("R1 reset status");
    chk_copy("R1 reset copy idle");
    for (int i = 0; i < NL; i++) chk_lookup(i, 0, "R1 R2 R3 identity read");
    chk_lookup(7, 1, "R2 program unlocked");
    chk_lookup(8, 2, "R2 erase unlocked");

    report(5);
    chk_copy("R5 copy raised");
    chk_status("R8 R6 count after accept");
    chk_lookup(5, 0, "R4 remapped to spare");
    chk_lookup(6, 0, "R4 neighbour unchanged");
    repeat (3) @(negedge clk);
    chk_copy("R5 copy held");

    report(9);
    chk_lookup(9, 0, "R6 pending report ignored");
    chk_status("R6 no spare consumed");
    chk_copy("R6 copy unchanged");

    ack();
    chk_copy("R5 cleared after ack");
    chk_status("R6 ready again");

    report(5);
    chk_copy("R7 spare of spare");
    chk_lookup(5, 0, "R7 remapped again");
    chk_lookup(5, 2, "R7 erase still allowed");
    ack();

    for (int b = 10; b < 16; b++) begin
      report(b);
      chk_copy("R3 ascending spare");
      chk_lookup(b, 0, "R4 remap");
      ack();
    end
    chk_status("R8 locked at zero");

    chk_lookup(10, 1, "R9 program refused");
    chk_lookup(3, 2, "R9 erase refused");
    chk_lookup(3, 3, "R9 reserved op refused");
    chk_lookup(15, 0, "R9 read under lock");
    chk_lookup(5, 0, "R9 read of spare under lock");

    report(20);
    chk_copy("R10 no copy when locked");
    chk_lookup(20, 0, "R10 mapping unchanged");
    chk_status("R10 R8 lock sticky");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule